// File: doc/BRIEF.md
# DSP Status Register with Flag Logic and Interrupt Gating

This block holds the 16-bit status word of a fixed-point DSP that works on a 40-bit accumulator. The ALU reports results to it. On an arithmetic update strobe it derives carry, overflow, zero, sign, a "does not fit in 32 bits" flag and a "top two middle-word bits agree" flag. On a logic update strobe it derives a logic-zero flag. Overflow also sets a sticky copy that later flag updates leave alone.

The upper bits of the word are mode controls. Software changes them one bit at a time with a set/clear command, or rewrites the whole word. Two of these modes gate how requests are accepted. One enable covers ordinary exceptions, and a request that arrives while it is clear is lost. Two separate enables cover the external interrupt. The second of those drops by itself whenever any exception is taken. Another mode selects saturation for stores taken from the accumulator's middle word. The block drives the resulting 16-bit store value.

Top module: `dsp_status_reg`

## Requirements
- R1: A synchronous active-high `rst` clears the status word to 0x0000 at the next clock edge.
- R2: On `arithUpd`, bit0 takes `carryIn` and bit1 takes `ovfIn`. Bit2 is set when the 40-bit `result` is zero. Bit3 takes result[39]. Bit4 is set when result[39:31] are not all equal, meaning the value differs from the sign extension of its low 32 bits. Bit5 is set when result[31] equals result[30]. Bit6 is unchanged.
- R3: Bit7 is set whenever an `arithUpd` has `ovfIn` high. A later `arithUpd` without overflow does not clear it. Only a full write clears it.
- R4: On `logicUpd`, bit6 is set exactly when `result` is zero. All other bits keep their value.
- R5: Bit8 always reads as 0, including after a full write of 1s.
- R6: `wrEn` loads `wrData` (with bit8 forced to 0) at the next edge. It overrides every update, command and strobe in that cycle.
- R7: With `cmdValid`, the bit named by `cmdIdx` is set (`cmdSet`=1) or cleared (`cmdSet`=0) at the next edge, but only for indices 9 to 15. Commands naming indices 0 to 8 change nothing.
- R8: A set/clear command has priority, for the bit it names, over flag logic and over the automatic clear of bit12 in the same cycle.
- R9: `excAccept` is `excReq` AND bit9, with no clock delay. A request seen while bit9 is clear is not remembered later.
- R10: `extIntAccept` is `extIntReq` AND (bit11 OR bit12), with no clock delay.
- R11: `excTaken` clears bit12 at the next edge and leaves bit11 and every other bit unchanged.
- R12: While bit14 is set, `storeVal` is 0x7FFF when `accIn` does not fit in 32 bits and `accIn`[39] is 0, and 0x8000 when it does not fit and `accIn`[39] is 1. Otherwise it is `accIn`[31:16].
- R13: While bit14 is clear, `storeVal` is `accIn`[31:16] with no saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| result | input | 40 | ALU result used for flag derivation |
| carryIn | input | 1 | Carry out of the ALU operation |
| ovfIn | input | 1 | Overflow out of the ALU operation |
| arithUpd | input | 1 | Update arithmetic flags (bits 0-5, sticky bit7) |
| logicUpd | input | 1 | Update logic-zero flag (bit6) |
| cmdValid | input | 1 | Single-bit command strobe |
| cmdSet | input | 1 | 1 = set the named bit, 0 = clear it |
| cmdIdx | input | 4 | Bit index for the command |
| wrEn | input | 1 | Full-word write strobe |
| wrData | input | 16 | Full-word write data |
| excReq | input | 1 | Exception request (non-external) |
| extIntReq | input | 1 | External interrupt request |
| excTaken | input | 1 | An exception was taken this cycle |
| accIn | input | 40 | Accumulator feeding the middle-word store |
| srOut | output | 16 | Current status word |
| excAccept | output | 1 | Exception accepted |
| extIntAccept | output | 1 | External interrupt accepted |
| storeVal | output | 16 | Middle-word store value, saturated per bit14 |

## Verification
The assertions check these on every cycle: bit8 reads as zero, the sticky bit persists and is set by overflow, both accept outputs follow their enables, bit12 drops after an exception is taken, out-of-range commands leave the word frozen, and the saturated store value follows the mode. The bench scenarios cover the parts that depend on data values. These are the exact flag patterns for chosen 40-bit results, the write and command priorities in colliding cycles, the fact that a dropped exception is not remembered, and the boundary values around the 32-bit fit test.

// File: rtl/dsp_sr_pkg.sv
package dsp_sr_pkg;
  localparam int SR_W   = 16;
  localparam int ACC_W  = 40;
  localparam int IDX_W  = $clog2(SR_W);
  localparam int FIT_LO = 31;  // lowest bit that must match the sign for a 32-bit fit
  localparam int MID_LO = 16;  // low bit of the middle word

  // status word bit positions
  localparam int B_CARRY  = 0;
  localparam int B_OVF    = 1;
  localparam int B_ZERO   = 2;
  localparam int B_SIGN   = 3;
  localparam int B_WIDE   = 4;
  localparam int B_TOP2   = 5;
  localparam int B_LZERO  = 6;
  localparam int B_STICKY = 7;
  localparam int B_RSVD   = 8;
  localparam int B_EXCEN  = 9;
  localparam int B_EXTEN  = 11;
  localparam int B_EXTEN2 = 12;
  localparam int B_MULMOD = 13;
  localparam int B_SAT    = 14;
  localparam int B_UMUL   = 15;
  localparam int CMD_LO   = 9;

  typedef struct packed {
    logic            loadAll;
    logic            flagLoad;
    logic            logicLoad;
    logic            autoClr;
    logic [SR_W-1:0] setMask;
    logic [SR_W-1:0] clrMask;
  } srStrobe_t;
endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl
  import dsp_sr_pkg::*;
#(
  parameter int CMD_FIRST = CMD_LO
) (
  input  logic             arithUpd,
  input  logic             logicUpd,
  input  logic             cmdValid,
  input  logic             cmdSet,
  input  logic [IDX_W-1:0] cmdIdx,
  input  logic             wrEn,
  input  logic             excTaken,
  input  logic             excReq,
  input  logic             extIntReq,
  input  logic [SR_W-1:0]  srQ,
  output srStrobe_t        strb,
  output logic             excAccept,
  output logic             extIntAccept
);
  logic [SR_W-1:0] hit;

  for (genvar i = 0; i < SR_W; i++) begin : g_hit
    if (i >= CMD_FIRST) begin : g_ok
      assign hit[i] = cmdValid && (cmdIdx == IDX_W'(i));
    end else begin : g_no
      assign hit[i] = 1'b0;
    end
  end

  always_comb begin
    strb.loadAll   = wrEn;
    strb.flagLoad  = arithUpd;
    strb.logicLoad = logicUpd;
    strb.autoClr   = excTaken;
    strb.setMask   = hit & {SR_W{cmdSet}};
    strb.clrMask   = hit & {SR_W{~cmdSet}};
  end

  assign excAccept    = excReq && srQ[B_EXCEN];
  assign extIntAccept = extIntReq && (srQ[B_EXTEN] || srQ[B_EXTEN2]);
endmodule

// File: rtl/sr_datapath.sv
module sr_datapath
  import dsp_sr_pkg::*;
#(
  parameter int ACC_BITS = ACC_W,
  parameter int FIT_BIT  = FIT_LO,
  parameter int MID_BIT  = MID_LO
) (
  input  logic                clk,
  input  logic                rst,
  input  srStrobe_t           strb,
  input  logic [ACC_BITS-1:0] result,
  input  logic                carryIn,
  input  logic                ovfIn,
  input  logic [SR_W-1:0]     wrData,
  input  logic [ACC_BITS-1:0] accIn,
  output logic [SR_W-1:0]     srQ,
  output logic [SR_W-1:0]     storeVal
);
  localparam int TOP_W = ACC_BITS - FIT_BIT;
  localparam int MID_W = FIT_BIT + 1 - MID_BIT;

  logic [SR_W-1:0] srNext;
  logic [5:0]      arithFlags;
  logic            resZero, resWide, accFits;

  assign resZero = (result == '0);
  assign resWide = !((&result[ACC_BITS-1:FIT_BIT]) || (result[ACC_BITS-1:FIT_BIT] == '0));
  assign accFits = (accIn[ACC_BITS-1:FIT_BIT] == {TOP_W{accIn[ACC_BITS-1]}});

  always_comb begin
    arithFlags[B_CARRY] = carryIn;
    arithFlags[B_OVF]   = ovfIn;
    arithFlags[B_ZERO]  = resZero;
    arithFlags[B_SIGN]  = result[ACC_BITS-1];
    arithFlags[B_WIDE]  = resWide;
    arithFlags[B_TOP2]  = (result[FIT_BIT] == result[FIT_BIT-1]);
  end

  always_comb begin
    srNext = srQ;
    if (strb.flagLoad) begin
      srNext[5:0] = arithFlags;
      if (ovfIn) srNext[B_STICKY] = 1'b1;
    end
    if (strb.logicLoad) srNext[B_LZERO] = resZero;
    if (strb.autoClr) srNext[B_EXTEN2] = 1'b0;
    srNext = (srNext | strb.setMask) & ~strb.clrMask;
    if (strb.loadAll) srNext = wrData;
    srNext[B_RSVD] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) srQ <= '0;
    else     srQ <= srNext;
  end

  always_comb begin
    if (srQ[B_SAT] && !accFits)
      storeVal = accIn[ACC_BITS-1] ? {1'b1, {(SR_W-1){1'b0}}} : {1'b0, {(SR_W-1){1'b1}}};
    else
      storeVal = SR_W'(accIn[FIT_BIT:MID_BIT]);
  end

  logic unusedMid;
  assign unusedMid = (MID_W == SR_W);
endmodule

// File: rtl/dsp_status_reg.sv
module dsp_status_reg
  import dsp_sr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  result,
  input  logic              carryIn,
  input  logic              ovfIn,
  input  logic              arithUpd,
  input  logic              logicUpd,
  input  logic              cmdValid,
  input  logic              cmdSet,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic              wrEn,
  input  logic [SR_W-1:0]   wrData,
  input  logic              excReq,
  input  logic              extIntReq,
  input  logic              excTaken,
  input  logic [ACC_W-1:0]  accIn,
  output logic [SR_W-1:0]   srOut,
  output logic              excAccept,
  output logic              extIntAccept,
  output logic [SR_W-1:0]   storeVal
);
  srStrobe_t strb;

  sr_ctrl u_ctrl (
    .arithUpd(arithUpd), .logicUpd(logicUpd), .cmdValid(cmdValid), .cmdSet(cmdSet),
    .cmdIdx(cmdIdx), .wrEn(wrEn), .excTaken(excTaken), .excReq(excReq),
    .extIntReq(extIntReq), .srQ(srOut), .strb(strb), .excAccept(excAccept),
    .extIntAccept(extIntAccept)
  );

  sr_datapath u_dp (
    .clk(clk), .rst(rst), .strb(strb), .result(result), .carryIn(carryIn), .ovfIn(ovfIn),
    .wrData(wrData), .accIn(accIn), .srQ(srOut), .storeVal(storeVal)
  );
endmodule

// File: rtl/dsp_status_reg_checker.sv
module dsp_status_reg_checker (
  input logic        clk,
  input logic        rst,
  input logic        ovfIn,
  input logic        arithUpd,
  input logic        logicUpd,
  input logic        cmdValid,
  input logic        cmdSet,
  input logic [3:0]  cmdIdx,
  input logic        wrEn,
  input logic        excReq,
  input logic        extIntReq,
  input logic        excTaken,
  input logic [39:0] accIn,
  input logic [15:0] srOut,
  input logic        excAccept,
  input logic        extIntAccept,
  input logic [15:0] storeVal
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (srOut == 16'h0000));

  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst) srOut[8] == 1'b0);

  // R3
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    (arithUpd && ovfIn && !wrEn) |=> srOut[7]);

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (srOut[7] && !wrEn) |=> srOut[7]);

  // R7
  cmd_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdIdx < 4'd9 && !wrEn && !arithUpd && !logicUpd && !excTaken) |=> $stable(srOut));

  // R9
  exc_gate_chk: assert property (@(posedge clk) disable iff (rst)
    excAccept == (excReq && srOut[9]));

  // R10
  ext_gate_chk: assert property (@(posedge clk) disable iff (rst)
    extIntAccept == (extIntReq && (srOut[11] || srOut[12])));

  // R11
  auto_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (excTaken && !wrEn && !(cmdValid && cmdSet && cmdIdx == 4'd12)) |=> !srOut[12]);

  // R11
  ext1_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (excTaken && srOut[11] && !wrEn && !(cmdValid && cmdIdx == 4'd11)) |=> srOut[11]);

  // R12
  sat_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (srOut[14] && !accIn[39] && accIn[39:31] != 9'h000) |-> (storeVal == 16'h7FFF));

  // R13
  nosat_chk: assert property (@(posedge clk) disable iff (rst)
    !srOut[14] |-> (storeVal == accIn[31:16]));
endmodule

bind dsp_status_reg dsp_status_reg_checker u_chk (
  .clk(clk), .rst(rst), .ovfIn(ovfIn), .arithUpd(arithUpd), .logicUpd(logicUpd),
  .cmdValid(cmdValid), .cmdSet(cmdSet), .cmdIdx(cmdIdx), .wrEn(wrEn), .excReq(excReq),
  .extIntReq(extIntReq), .excTaken(excTaken), .accIn(accIn), .srOut(srOut),
  .excAccept(excAccept), .extIntAccept(extIntAccept), .storeVal(storeVal)
);

// File: tb/dsp_status_reg_test.sv
module dsp_status_reg_test;
  logic        clk = 0, rst = 1;
  logic [39:0] result = '0, accIn = '0;
  logic        carryIn = 0, ovfIn = 0, arithUpd = 0, logicUpd = 0;
  logic        cmdValid = 0, cmdSet = 0, wrEn = 0;
  logic [3:0]  cmdIdx = '0;
  logic [15:0] wrData = '0;
  logic        excReq = 0, extIntReq = 0, excTaken = 0;
  logic [15:0] srOut, storeVal;
  logic        excAccept, extIntAccept;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    int          kind;  // 0 srOut, 1 excAccept, 2 extIntAccept, 3 storeVal
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  dsp_status_reg uut (
    .clk(clk), .rst(rst), .result(result), .carryIn(carryIn), .ovfIn(ovfIn),
    .arithUpd(arithUpd), .logicUpd(logicUpd), .cmdValid(cmdValid), .cmdSet(cmdSet),
    .cmdIdx(cmdIdx), .wrEn(wrEn), .wrData(wrData), .excReq(excReq), .extIntReq(extIntReq),
    .excTaken(excTaken), .accIn(accIn), .srOut(srOut), .excAccept(excAccept),
    .extIntAccept(extIntAccept), .storeVal(storeVal)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    arithUpd = 0; logicUpd = 0; cmdValid = 0; wrEn = 0; excTaken = 0;
    carryIn = 0; ovfIn = 0;
  endtask

  task automatic expect_item(input int kind, input logic [15:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  // apply a registered step: drive, clock, then expect status word
  task automatic step_sr(input logic [15:0] exp, input string req);
    tick();
    idle();
    expect_item(0, exp, req);
  endtask

  task automatic cmd(input logic s, input int idx);
    cmdValid = 1; cmdSet = s; cmdIdx = 4'(idx);
  endtask

  // monitor: compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = srOut;
          1: act = {15'd0, excAccept};
          2: act = {15'd0, extIntAccept};
          default: act = storeVal;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    expect_item(0, 16'h0000, "R1 reset");
    tick();
    rst = 0;

    // R2 zero result: zero flag and top-two-equal
    arithUpd = 1; result = 40'h00_0000_0000;
    step_sr(16'h0024, "R2 zero result");
    // R2 does not fit in 32 bits, carry set
    arithUpd = 1; carryIn = 1; result = 40'h01_0000_0000;
    step_sr(16'h0031, "R2 wide result");
    // R2 R3 negative fits, overflow sets sticky
    arithUpd = 1; ovfIn = 1; result = 40'hFF_8000_0000;
    step_sr(16'h008A, "R3 overflow sets sticky");
    // R3 sticky survives a clean update
    arithUpd = 1; result = 40'h00_4000_0000;
    step_sr(16'h0080, "R3 sticky kept");
    // R4 logic zero
    logicUpd = 1; result = 40'h00_0000_0000;
    step_sr(16'h00C0, "R4 logic zero");
    // R2 arithmetic update leaves bit6
    arithUpd = 1; result = 40'h00_0000_0000;
    step_sr(16'h00E4, "R2 bit6 unchanged");
    // R4 nonzero clears bit6 only
    logicUpd = 1; result = 40'h00_0000_0100;
    step_sr(16'h00A4, "R4 nonzero logic");
    // R5 R6 full write overrides command and update
    wrEn = 1; wrData = 16'hFFFF; cmd(0, 9); arithUpd = 1; result = 40'h01_0000_0000;
    step_sr(16'hFEFF, "R5 R6 full write");
    wrEn = 1; wrData = 16'h0000;
    step_sr(16'h0000, "R6 R3 write clears sticky");
    // R7 range
    cmd(1, 9);
    step_sr(16'h0200, "R7 set bit9");
    cmd(1, 7);
    step_sr(16'h0200, "R7 index7 ignored");
    cmd(1, 8);
    step_sr(16'h0200, "R7 index8 ignored");
    cmd(1, 0);
    step_sr(16'h0200, "R7 index0 ignored");
    cmd(1, 11);
    step_sr(16'h0A00, "R7 set bit11");
    cmd(1, 12);
    step_sr(16'h1A00, "R7 set bit12");
    // R9 R10 accept
    excReq = 1; extIntReq = 1;
    expect_item(1, 16'h0001, "R9 accept enabled");
    expect_item(2, 16'h0001, "R10 accept enabled");
    tick();
    excReq = 0; extIntReq = 0;
    // R11 exception taken clears bit12 only
    excTaken = 1;
    step_sr(16'h0A00, "R11 auto clear");
    extIntReq = 1;
    expect_item(2, 16'h0001, "R10 bit11 alone");
    tick();
    cmd(0, 11);
    step_sr(16'h0200, "R7 clear bit11");
    expect_item(2, 16'h0000, "R10 both enables clear");
    tick();
    extIntReq = 0;
    cmd(0, 9);
    step_sr(16'h0000, "R7 clear bit9");
    excReq = 1;
    expect_item(1, 16'h0000, "R9 disabled");
    tick();
    excReq = 0; cmd(1, 9);
    step_sr(16'h0200, "R9 re-enable");
    expect_item(1, 16'h0000, "R9 not queued");
    tick();
    // R8 command beats auto clear and flag logic
    cmd(1, 12); excTaken = 1;
    step_sr(16'h1200, "R8 command over auto clear");
    cmd(1, 13); arithUpd = 1; result = 40'h00_0000_0000;
    step_sr(16'h3224, "R8 command with flags");
    // R12 R13 saturation
    wrEn = 1; wrData = 16'h4000;
    step_sr(16'h4000, "R6 sat mode");
    accIn = 40'h01_2345_6789;
    expect_item(3, 16'h7FFF, "R12 positive saturate");
    tick();
    accIn = 40'hFE_0000_0000;
    expect_item(3, 16'h8000, "R12 negative saturate");
    tick();
    accIn = 40'h00_1234_5678;
    expect_item(3, 16'h1234, "R12 fits");
    tick();
    accIn = 40'hFF_8000_0000;
    expect_item(3, 16'h8000, "R12 negative boundary fits");
    tick();
    wrEn = 1; wrData = 16'h0000;
    step_sr(16'h0000, "R6 linear mode");
    accIn = 40'h01_2345_6789;
    expect_item(3, 16'h2345, "R13 no saturation");
    tick();
    tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule